// File: doc/BRIEF.md
# Clock Generator Control Registers

This block keeps the bus-side control and status state for a clock generator that has an external oscillator path and a programmable frequency multiplier. Software reaches it through a byte-wide read/write port on the bus clock. The block drives the enable line of the external oscillator and presents a 7-bit multiplier factor to the generator. It reports, through a stable flag, that a fixed startup delay has passed since the oscillator was switched on.

Clock selection and clock monitoring are controlled by two bits that live elsewhere and enter as inputs. While either bit is high, the oscillator enable is held on. Software can switch the oscillator off only after both bits have been low for a full bus cycle. The startup delay is counted in the external clock domain. The result crosses into the bus domain through a synchronizer. An inactive indication from the clock monitor drops the stable flag at once and restarts the count. The multiplier register cannot be written while monitoring is on. A stored zero is presented to the generator as one.

Top module: `clk_gen_regs`

## Requirements
- R1: After reset the oscillator enable is 0, the stable flag is 0, the multiplier register reads 0x15 and the factor output is 21.
- R2: A bus clock edge at which clkSel or monEn is 1 leaves the oscillator enable at 1 after that edge, even when a write of 0 to the control register happens at the same edge.
- R3: Writing bit 0 = 1 to the control register (address 0) sets the enable. Writing bit 0 = 0 clears it only if clkSel and monEn were both 0 at that edge and at the bus edge before it. Otherwise the write leaves the enable unchanged.
- R4: With the enable on and the inactive indication low, the stable flag rises only after at least 4096 rising edges of extClk since the enable was set. It then appears within the two-flop synchronizer latency, which is at most three bus cycles.
- R5: The stable flag reads 0 in the same cycle that extInactive is 1 or the enable is 0. After extInactive returns low, the full 4096-edge delay starts again from zero.
- R6: A write to the multiplier register (address 1) at a bus edge where monEn is 1 is ignored.
- R7: The factor output equals the stored 7-bit value, except that a stored 0 is output as 1. A read of address 1 returns the raw stored value in bits 6:0 with bit 7 = 0, and bit 7 of the write data is discarded.
- R8: Reading address 0 returns the enable in bit 0 and the stable flag in bit 1, with bits 7:2 = 0. Bit 1 is read-only. rdData follows addr combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Bus clock |
| busRstN | input | 1 | Asynchronous active-low reset |
| extClk | input | 1 | External oscillator clock |
| wrEn | input | 1 | Write strobe, sampled on busClk |
| addr | input | 1 | Register select: 0 control, 1 multiplier |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| clkSel | input | 1 | Clock-select control bit |
| monEn | input | 1 | Clock-monitor enable control bit |
| extInactive | input | 1 | Monitor reports the external clock inactive |
| extOscEn | output | 1 | External oscillator enable |
| extStable | output | 1 | Startup delay elapsed flag |
| multFactor | output | 7 | Multiplier factor, zero mapped to one |

## Verification
The bench targets the clear that comes one cycle after clkSel drops. A design that skips the one-cycle qualification would switch the oscillator off there, while the correct design keeps it on. It measures the stable flag against an independently counted number of extClk edges, on a clock whose period does not divide the bus period. An early flag would show a short count, and a missing synchronizer stage or a stuck counter would show a long one or a timeout. It drops the inactive indication in the middle of a count. A design that did not restart the count would recover too fast. It writes the multiplier on the cycle monEn falls and with a zero value, which catches a lock that lingers a cycle and a factor of 0 reaching the output.

// File: rtl/clk_gen_pkg.sv
package clk_gen_pkg;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_MULT = 1'b1;

  // strobes handed from control to datapath, one bus cycle each
  typedef struct packed {
    logic forceOn;   // clkSel or monEn high this edge
    logic swSet;     // software writes enable = 1
    logic swClear;   // qualified software clear of enable
    logic multWr;    // unlocked write to the multiplier register
  } ctrlStrobes_t;

endpackage

// File: rtl/clk_gen_startcnt.sv
module clk_gen_startcnt #(
  parameter int TERM_COUNT = 4096
) (
  input  logic extClk,
  input  logic runN,
  output logic done
);
  localparam int CW = $clog2(TERM_COUNT + 1);
  localparam logic [CW-1:0] TERM = CW'(TERM_COUNT);

  logic [CW-1:0] cnt;

  always_ff @(posedge extClk or negedge runN) begin
    if (!runN) begin
      cnt <= '0;
    end else if (cnt != TERM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt == TERM);

  // R4
  sat_hold_chk: assert property (@(posedge extClk) disable iff (!runN)
    done |=> done);

endmodule

// File: rtl/clk_gen_ctrl.sv
module clk_gen_ctrl
  import clk_gen_pkg::*;
(
  input  logic         busClk,
  input  logic         busRstN,
  input  logic         wrEn,
  input  logic         addr,
  input  logic         wrBit0,
  input  logic         clkSel,
  input  logic         monEn,
  output ctrlStrobes_t strb
);
  logic qualReg;
  logic ctrlWr;

  // set when both control bits were low at the previous edge
  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      qualReg <= 1'b0;
    end else begin
      qualReg <= !clkSel && !monEn;
    end
  end

  assign ctrlWr = wrEn && (addr == ADDR_CTRL);

  always_comb begin
    strb.forceOn = clkSel || monEn;
    strb.swSet   = ctrlWr && wrBit0;
    strb.swClear = ctrlWr && !wrBit0 && qualReg && !strb.forceOn;
    strb.multWr  = wrEn && (addr == ADDR_MULT) && !monEn;
  end

endmodule

// File: rtl/clk_gen_dp.sv
module clk_gen_dp
  import clk_gen_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int MULT_W       = 7,
  parameter int MULT_RESET   = 21,
  parameter int START_CYCLES = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              extClk,
  input  logic              extInactive,
  input  ctrlStrobes_t      strb,
  input  logic              addr,
  input  logic [MULT_W-1:0] wrMult,
  output logic              extEn,
  output logic              stable,
  output logic [MULT_W-1:0] factor,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [MULT_W-1:0] MULT_INIT = MULT_W'(MULT_RESET);
  localparam logic [MULT_W-1:0] MULT_ONE  = MULT_W'(1);

  logic [MULT_W-1:0]      multReg;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   cntRunN;
  logic                   cntDone;
  logic                   flagClr;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      extEn <= 1'b0;
    end else if (strb.forceOn || strb.swSet) begin
      extEn <= 1'b1;
    end else if (strb.swClear) begin
      extEn <= 1'b0;
    end
  end

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      multReg <= MULT_INIT;
    end else if (strb.multWr) begin
      multReg <= wrMult;
    end
  end

  assign factor = (multReg == '0) ? MULT_ONE : multReg;

  // startup delay counter lives in the external domain
  assign cntRunN = busRstN && extEn && !extInactive;

  clk_gen_startcnt #(
    .TERM_COUNT(START_CYCLES)
  ) startcnt_i (
    .extClk(extClk),
    .runN  (cntRunN),
    .done  (cntDone)
  );

  assign flagClr = !extEn || extInactive;

  always_ff @(posedge busClk or negedge busRstN) begin
    if (!busRstN) begin
      syncQ <= '0;
    end else if (flagClr) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], cntDone};
    end
  end

  assign stable = syncQ[SYNC_STAGES-1] && !flagClr;

  always_comb begin
    rdData = '0;
    if (addr == ADDR_CTRL) begin
      rdData[0] = extEn;
      rdData[1] = stable;
    end else begin
      rdData[MULT_W-1:0] = multReg;
    end
  end

  // R4
  stable_after_en_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    $rose(stable) |-> ($past(extEn) && $past(extEn, 2)));

endmodule

// File: rtl/clk_gen_regs.sv
module clk_gen_regs
  import clk_gen_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int MULT_W       = 7,
  parameter int MULT_RESET   = 21,
  parameter int START_CYCLES = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              busClk,
  input  logic              busRstN,
  input  logic              extClk,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              clkSel,
  input  logic              monEn,
  input  logic              extInactive,
  output logic              extOscEn,
  output logic              extStable,
  output logic [MULT_W-1:0] multFactor
);
  ctrlStrobes_t strb;

  clk_gen_ctrl ctrl_i (
    .busClk (busClk),
    .busRstN(busRstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrBit0 (wrData[0]),
    .clkSel (clkSel),
    .monEn  (monEn),
    .strb   (strb)
  );

  clk_gen_dp #(
    .DATA_W      (DATA_W),
    .MULT_W      (MULT_W),
    .MULT_RESET  (MULT_RESET),
    .START_CYCLES(START_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .busClk     (busClk),
    .busRstN    (busRstN),
    .extClk     (extClk),
    .extInactive(extInactive),
    .strb       (strb),
    .addr       (addr),
    .wrMult     (wrData[MULT_W-1:0]),
    .extEn      (extOscEn),
    .stable     (extStable),
    .factor     (multFactor),
    .rdData     (rdData)
  );

  // R2
  forced_on_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    (clkSel || monEn) |=> extOscEn);

  // R3
  clear_qual_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    $fell(extOscEn) |-> ($past(!clkSel && !monEn) && $past(!clkSel && !monEn, 2)));

  // R6
  mult_lock_chk: assert property (@(posedge busClk) disable iff (!busRstN)
    monEn |=> $stable(multFactor));

endmodule

// File: tb/clk_gen_regs_tb_top.sv
`timescale 1ns/1ps
module clk_gen_regs_tb_top;

  logic       busClk = 1'b0;
  logic       extClk = 1'b0;
  logic       busRstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = '0;
  logic       clkSel = 1'b0;
  logic       monEn = 1'b0;
  logic       extInactive = 1'b0;
  logic [7:0] rdData;
  logic       extOscEn;
  logic       extStable;
  logic [6:0] multFactor;

  int nChecks = 0;
  int nFail = 0;
  int extEdges = 0;

  logic       mEn = 1'b0;
  logic       mQual = 1'b0;
  logic [6:0] mMult = 7'd21;

  clk_gen_regs dut_i (
    .busClk(busClk), .busRstN(busRstN), .extClk(extClk),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .clkSel(clkSel), .monEn(monEn), .extInactive(extInactive),
    .extOscEn(extOscEn), .extStable(extStable), .multFactor(multFactor)
  );

  always #10 busClk = ~busClk;
  initial begin
    #3;
    forever #6.5 extClk = ~extClk;
  end

  // independent count of external edges since the enable came on
  always @(posedge extClk) begin
    if (extOscEn && !extInactive) extEdges <= extEdges + 1;
    else extEdges <= 0;
  end

  function automatic logic [6:0] expFactor(input logic [6:0] m);
    return (m == 7'd0) ? 7'd1 : m;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input string what, input int act, input int lo, input int hi);
    nChecks++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  // one bus cycle: drive at negedge, model at posedge, return at next negedge
  task automatic cycle(input logic we, input logic a, input logic [7:0] d,
                       input logic cs, input logic mon, input logic inact);
    wrEn = we; addr = a; wrData = d; clkSel = cs; monEn = mon; extInactive = inact;
    @(posedge busClk);
    if (cs || mon) mEn = 1'b1;
    else if (we && a == 1'b0) begin
      if (d[0]) mEn = 1'b1;
      else if (mQual) mEn = 1'b0;
    end
    mQual = !cs && !mon;
    if (we && a == 1'b1 && !mon) mMult = d[6:0];
    @(negedge busClk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic waitStable(output bit seen);
    seen = 0;
    wrEn = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge busClk);
      if (extStable) begin
        seen = 1;
        break;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    bit seen;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge busClk);
    // R1 reset state
    chk("R1", "enable in reset", int'(extOscEn), 0);
    busRstN = 1'b1;
    @(negedge busClk);
    chk("R1", "enable", int'(extOscEn), 0);
    chk("R1", "stable", int'(extStable), 0);
    chk("R1", "factor", int'(multFactor), 21);
    addr = 1'b1; #1;
    chk("R1", "mult read", int'(rdData), 8'h15);
    addr = 1'b0; #1;
    chk("R8", "ctrl read after reset", int'(rdData), 0);
    mQual = 1'b0;
    idle(1);

    // R3 software set, then qualified clear
    cycle(1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0);
    chk("R3", "write 1 sets", int'(extOscEn), 1);
    cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3", "qualified clear", int'(extOscEn), 0);
    // R2 forcing beats a clear write
    cycle(1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R2", "clkSel forces on", int'(extOscEn), 1);
    cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3", "clear one cycle after clkSel ignored", int'(extOscEn), 1);
    cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R2", "monEn forces on", int'(extOscEn), 1);
    cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3", "clear one cycle after monEn ignored", int'(extOscEn), 1);
    cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3", "clear after full quiet cycle", int'(extOscEn), 0);

    // R7 zero maps to one, bit 7 discarded
    cycle(1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R7", "factor of zero", int'(multFactor), 1);
    #1 chk("R7", "raw zero readback", int'(rdData), 0);
    cycle(1'b1, 1'b1, 8'h7F, 1'b0, 1'b0, 1'b0);
    chk("R7", "factor max", int'(multFactor), 127);
    cycle(1'b1, 1'b1, 8'h85, 1'b0, 1'b0, 1'b0);
    #1 chk("R7", "bit7 dropped", int'(rdData), 8'h05);
    // R6 write lock and release on the falling cycle of monEn
    cycle(1'b1, 1'b1, 8'h33, 1'b0, 1'b1, 1'b0);
    chk("R6", "locked write", int'(multFactor), 5);
    cycle(1'b1, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0);
    chk("R6", "write after monEn low", int'(multFactor), 8'h33);
    idle(2);
    cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R3", "enable off before startup test", int'(extOscEn), 0);

    // R4 startup delay
    cycle(1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0);
    chk("R4", "stable low right after enable", int'(extStable), 0);
    waitStable(seen);
    chk("R4", "stable seen", int'(seen), 1);
    chkRange("R4", "ext edges at stable", extEdges, 4096, 4102);
    addr = 1'b0; #1;
    chk("R8", "ctrl read with stable", int'(rdData), 3);
    // R8 bit 1 is read-only
    cycle(1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0);
    #1 chk("R8", "stable write has no effect", int'(rdData), 3);

    // R5 inactive drops flag at once and restarts the count
    extInactive = 1'b1; #1;
    chk("R5", "inactive clears stable", int'(extStable), 0);
    cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    cycle(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R5", "stable low while inactive", int'(extStable), 0);
    idle(100);
    chk("R5", "stable low during restart", int'(extStable), 0);
    waitStable(seen);
    chk("R5", "stable after restart", int'(seen), 1);
    chkRange("R5", "ext edges after restart", extEdges, 4096, 4102);
    cycle(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R5", "enable clear drops stable", int'(extStable), 0);

    // random phase against the model
    for (int i = 0; i < 400; i++) begin
      logic we, a, cs, mon, inact;
      logic [7:0] d;
      we = $urandom_range(0, 1) == 1;
      a = $urandom_range(0, 1) == 1;
      d = 8'($urandom);
      if ($urandom_range(0, 3) == 0) d[6:0] = 7'd0;
      cs = $urandom_range(0, 3) == 0;
      mon = $urandom_range(0, 3) == 0;
      inact = $urandom_range(0, 7) == 0;
      cycle(we, a, d, cs, mon, inact);
      chk("R2", "random enable", int'(extOscEn), int'(mEn));
      chk("R7", "random factor", int'(multFactor), int'(expFactor(mMult)));
      if (a) chk("R6", "random mult read", int'(rdData), int'({1'b0, mMult}));
      else   chk("R8", "random ctrl read", int'(rdData & 8'hFD), int'(mEn));
      if (!mEn || inact) chk("R5", "random stable forced low", int'(extStable), 0);
    end

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule